// File: doc/BRIEF.md
# Relative Branch Resolver

This block resolves one conditional relative branch of an 8-bit processor with a 16-bit address space. It takes the address of the instruction that follows the branch, a signed 8-bit displacement, the four status flags (negative, overflow, zero, carry) and a 3-bit condition code. It returns three things: whether the branch is taken, the program counter at which execution continues, and how many bus cycles the branch occupies. The cycle count is 2 when the branch is not taken, 3 when it is taken within the same 256-byte page, and 4 when it is taken into another page.

A request is accepted on a cycle where `req_valid` and `req_ready` are both high. The result appears on the result ports one clock later, marked by a single-cycle `res_valid` pulse, and stays there until the next accepted request. The block then paces itself to the branch it has just resolved. After accepting a request, it holds `req_ready` low until as many clock edges have passed as the branch costs. A caller that keeps presenting requests therefore sees each branch take its real duration.

Top module: `branch_resolver`

## Requirements
- R1: The condition code is split into a flag selector in bits 2:1 (00 negative, 01 overflow, 10 carry, 11 zero) and a required flag value in bit 0. The branch is taken exactly when the selected flag equals bit 0.
- R2: A branch that is not taken reports `res_pc` equal to the presented `req_next_pc` and `res_cycles` equal to 2.
- R3: A taken branch reports `res_pc` equal to `req_next_pc` plus the sign-extended `req_offset`, modulo 65536.
- R4: A taken branch whose target has the same high byte as `req_next_pc` reports `res_cycles` equal to 3.
- R5: A taken branch whose target high byte differs from that of `req_next_pc` reports `res_cycles` equal to 4.
- R6: Offset 80 hex is a displacement of -128, and 7F hex is +127.
- R7: A taken forward branch from page FF hex that passes the top of memory continues in page 00 and costs 4 cycles.
- R8: A taken backward branch from page 00 hex that passes address zero continues in page FF and costs 4 cycles.
- R9: A taken branch with offset 00 continues at `req_next_pc` and costs 3 cycles.
- R10: After an accepted request, `req_ready` stays low for `res_cycles` minus 1 clock cycles. A `req_valid` presented while `req_ready` is low is ignored: it produces no `res_valid` and leaves the result ports unchanged.
- R11: Out of reset `res_valid` is 0 and `req_ready` is 1. Each accepted request produces exactly one `res_valid` pulse, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_next_pc | input | 16 | Address of the instruction after the branch |
| req_offset | input | 8 | Signed branch displacement |
| req_cond | input | 3 | Condition code: flag selector in bits 2:1, required value in bit 0 |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| res_valid | output | 1 | One-cycle pulse: result ports are updated |
| res_taken | output | 1 | Branch taken |
| res_pc | output | 16 | Address where execution continues |
| res_cycles | output | 3 | Cycles consumed by the branch (2, 3 or 4) |

## Verification
The wrap across the top or bottom of memory and the page-cross surcharge happen in the same evaluation. A branch that wraps always changes the high byte of the address. These cases are provoked with a forward branch from address FFF0 hex and a backward branch of -128 from address 0010 hex. The bench judges the wrapped target and the 4-cycle cost together.

Pacing and the result pulse also overlap: `res_valid` rises while `req_ready` is still low. The bench counts the low-ready cycles that follow each result, and it drives requests during that window to confirm they are dropped.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int CYC_W = 3;

  typedef enum logic [1:0] {
    FSEL_NEG  = 2'b00,
    FSEL_OVF  = 2'b01,
    FSEL_CARRY = 2'b10,
    FSEL_ZERO = 2'b11
  } flag_sel_e;

  localparam logic [CYC_W-1:0] CYC_SKIP = 3'd2;
  localparam logic [CYC_W-1:0] CYC_NEAR = 3'd3;
  localparam logic [CYC_W-1:0] CYC_FAR  = 3'd4;
endpackage

// File: rtl/branch_cond.sv
module branch_cond
  import branch_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       flag_n,
  input  logic       flag_v,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       taken
);
  flag_sel_e sel;
  logic      picked;

  always_comb begin
    sel = flag_sel_e'(cond[2:1]);
    unique case (sel)
      FSEL_NEG:   picked = flag_n;
      FSEL_OVF:   picked = flag_v;
      FSEL_CARRY: picked = flag_c;
      default:    picked = flag_z;
    endcase
    taken = (picked == cond[0]);
  end

  always_comb begin
    a_r1_taken_matches_flag: assert (taken == ((cond[0] & picked) | (~cond[0] & ~picked)));
  end
endmodule

// File: rtl/branch_target.sv
module branch_target #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  offset,
  output logic [ADDR_W-1:0] target,
  output logic              crosses
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ext_ofs;

  always_comb begin
    ext_ofs = {{EXT_W{offset[OFS_W-1]}}, offset};
    target  = base + ext_ofs;
    crosses = (target[ADDR_W-1:PAGE_W] != base[ADDR_W-1:PAGE_W]);
  end
endmodule

// File: rtl/branch_pacer.sv
module branch_pacer
  import branch_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CYC_W-1:0] load_cycles,
  output logic             ready,
  output logic             pulse
);
  logic [CNT_W-1:0] busy_q, busy_d;
  logic             pulse_q, pulse_d;
  logic [CYC_W-1:0] remain;

  always_comb begin
    remain  = load_cycles - CYC_W'(1);
    pulse_d = accept;
    if (accept)
      busy_d = remain[CNT_W-1:0];
    else if (busy_q != '0)
      busy_d = busy_q - CNT_W'(1);
    else
      busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      pulse_q <= pulse_d;
    end
  end

  assign ready = (busy_q == '0);
  assign pulse = pulse_q;

  a_r10_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !accept);
  a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q != '0) |=> (busy_q == $past(busy_q) - CNT_W'(1)));
  a_r11_pulse_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pulse);
  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_next_pc,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [2:0]        req_cond,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic              res_valid,
  output logic              res_taken,
  output logic [ADDR_W-1:0] res_pc,
  output logic [CYC_W-1:0]  res_cycles
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              accept;
  logic              taken;
  logic              crosses;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pc_d,  pc_q;
  logic [CYC_W-1:0]  cyc_d, cyc_q;
  logic              tk_q;

  branch_cond u_cond (
    .cond   (req_cond),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .taken  (taken)
  );

  branch_target #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_target (
    .base    (req_next_pc),
    .offset  (req_offset),
    .target  (target),
    .crosses (crosses)
  );

  branch_pacer #(.CNT_W(2)) u_pacer (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .load_cycles (cyc_d),
    .ready       (req_ready),
    .pulse       (res_valid)
  );

  always_comb begin
    accept = req_valid & req_ready;
    pc_d   = taken ? target : req_next_pc;
    if (!taken)
      cyc_d = CYC_SKIP;
    else if (crosses)
      cyc_d = CYC_FAR;
    else
      cyc_d = CYC_NEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_q  <= 1'b0;
      pc_q  <= '0;
      cyc_q <= CYC_SKIP;
    end else if (accept) begin
      tk_q  <= taken;
      pc_q  <= pc_d;
      cyc_q <= cyc_d;
    end
  end

  assign res_taken  = tk_q;
  assign res_pc     = pc_q;
  assign res_cycles = cyc_q;

  a_r2_skip_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |-> (res_cycles == CYC_SKIP && res_pc == $past(req_next_pc)));
  a_r4_same_page_three: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken && res_pc[ADDR_W-1:PAGE_W] == $past(req_next_pc[ADDR_W-1:PAGE_W]))
      |-> (res_cycles == CYC_NEAR));
  a_r5_other_page_four: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken && res_pc[ADDR_W-1:PAGE_W] != $past(req_next_pc[ADDR_W-1:PAGE_W]))
      |-> (res_cycles == CYC_FAR));
  a_r3_target_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |->
      (res_pc == $past(req_next_pc) + {{(ADDR_W-OFS_W){$past(req_offset[OFS_W-1])}}, $past(req_offset)}));
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(res_pc) && $stable(res_cycles) && $stable(res_taken)));
  a_r11_ready_low_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);
  a_r5_high_part_width: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_cycles == CYC_FAR) |-> (res_taken && HI_W > 0));
endmodule

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_next_pc;
  logic [7:0]  req_offset;
  logic [2:0]  req_cond;
  logic        flag_n, flag_v, flag_z, flag_c;
  logic        res_valid;
  logic        res_taken;
  logic [15:0] res_pc;
  logic [2:0]  res_cycles;

  int checks;
  int errors;
  bit done;

  branch_resolver u_branch_resolver (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_next_pc (req_next_pc),
    .req_offset  (req_offset),
    .req_cond    (req_cond),
    .flag_n      (flag_n),
    .flag_v      (flag_v),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_pc      (res_pc),
    .res_cycles  (res_cycles)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flg packs {n, v, z, c}
  task automatic run_case(input logic [15:0] npc, input logic [7:0] ofs, input logic [2:0] cnd,
                          input logic [3:0] flg, input logic exp_tk, input logic [15:0] exp_pc,
                          input logic [2:0] exp_cyc, input string tag);
    int lows;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_next_pc = npc;
    req_offset  = ofs;
    req_cond    = cnd;
    {flag_n, flag_v, flag_z, flag_c} = flg;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid   = 1'b0;
    check({tag, " R11 res_valid"}, 32'(res_valid), 32'd1);
    check({tag, " taken"}, 32'(res_taken), 32'(exp_tk));
    check({tag, " pc"}, 32'(res_pc), 32'(exp_pc));
    check({tag, " cycles"}, 32'(res_cycles), 32'(exp_cyc));
    lows = 0;
    while (!req_ready && lows < 10) begin
      lows++;
      @(negedge clk);
    end
    check({tag, " R10 busy length"}, 32'(lows), 32'(exp_cyc) - 32'd1);
  endtask

  function automatic logic [15:0] model_target(input logic [15:0] npc, input logic [7:0] ofs);
    return npc + {{8{ofs[7]}}, ofs};
  endfunction

  task automatic test_reset();
    check("R11 reset res_valid", 32'(res_valid), 32'd0);
    check("R11 reset req_ready", 32'(req_ready), 32'd1);
  endtask

  task automatic test_not_taken();
    run_case(16'h1234, 8'h10, 3'b111, 4'b0000, 1'b0, 16'h1234, 3'd2, "R2 zero-set false");
    run_case(16'h12F0, 8'h40, 3'b100, 4'b0001, 1'b0, 16'h12F0, 3'd2, "R2 carry-clear false");
  endtask

  task automatic test_same_page();
    run_case(16'h1210, 8'h7F, 3'b001, 4'b1000, 1'b1, 16'h128F, 3'd3, "R3 R4 R6 plus 7F");
    run_case(16'h1290, 8'h80, 3'b010, 4'b0000, 1'b1, 16'h1210, 3'd3, "R4 R6 minus 80 same page");
    run_case(16'h3355, 8'hFD, 3'b110, 4'b0000, 1'b1, 16'h3352, 3'd3, "R3 R4 minus 3");
  endtask

  task automatic test_cross_page();
    run_case(16'h12F0, 8'h20, 3'b101, 4'b0001, 1'b1, 16'h1310, 3'd4, "R5 forward cross");
    run_case(16'h1250, 8'h80, 3'b011, 4'b0100, 1'b1, 16'h11D0, 3'd4, "R5 R6 minus 80 cross");
    run_case(16'h3300, 8'hFF, 3'b000, 4'b0000, 1'b1, 16'h32FF, 3'd4, "R5 minus 1 cross");
  endtask

  task automatic test_wrap();
    run_case(16'hFFF0, 8'h20, 3'b111, 4'b0010, 1'b1, 16'h0010, 3'd4, "R7 forward wrap");
    run_case(16'hFF81, 8'h7F, 3'b100, 4'b0000, 1'b1, 16'h0000, 3'd4, "R7 wrap to zero");
    run_case(16'h0010, 8'h80, 3'b001, 4'b1000, 1'b1, 16'hFF90, 3'd4, "R8 backward wrap");
    run_case(16'h0000, 8'hFF, 3'b110, 4'b0000, 1'b1, 16'hFFFF, 3'd4, "R8 wrap from zero");
  endtask

  task automatic test_zero_offset();
    run_case(16'h4000, 8'h00, 3'b011, 4'b0100, 1'b1, 16'h4000, 3'd3, "R9 zero offset");
    run_case(16'h40FF, 8'h00, 3'b000, 4'b0000, 1'b1, 16'h40FF, 3'd3, "R9 zero offset page end");
  endtask

  task automatic test_busy_ignore();
    logic [15:0] held_pc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_next_pc = 16'h20F8; req_offset = 8'h10; req_cond = 3'b101; // carry set
    {flag_n, flag_v, flag_z, flag_c} = 4'b0001;
    req_valid = 1'b1;
    @(negedge clk);
    check("R10 setup pc", 32'(res_pc), 32'h2108);
    held_pc = res_pc;
    req_next_pc = 16'h5555; req_offset = 8'h01; req_cond = 3'b000;
    {flag_n, flag_v, flag_z, flag_c} = 4'b0000;
    check("R10 ready low while busy", 32'(req_ready), 32'd0);
    @(negedge clk);
    check("R10 no pulse while busy", 32'(res_valid), 32'd0);
    check("R10 pc unchanged while busy", 32'(res_pc), 32'(held_pc));
    @(negedge clk);
    check("R10 no pulse while busy 2", 32'(res_valid), 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 ready returns", 32'(req_ready), 32'd1);
    check("R10 pc still held", 32'(res_pc), 32'(held_pc));
    check("R10 cycles still held", 32'(res_cycles), 32'd4);
  endtask

  task automatic test_cond_sweep();
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 16; f++) begin
        logic [3:0] flg;
        logic       pick, tk;
        logic [15:0] tgt;
        flg = 4'(f);
        case (s >> 1)
          0: pick = flg[3];
          1: pick = flg[2];
          2: pick = flg[0];
          default: pick = flg[1];
        endcase
        tk  = (pick == s[0]);
        tgt = model_target(16'h8040, 8'h05);
        run_case(16'h8040, 8'h05, 3'(s), flg, tk, tk ? tgt : 16'h8040,
                 tk ? 3'd3 : 3'd2, "R1 sweep");
      end
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; req_valid = 1'b0;
    req_next_pc = '0; req_offset = '0; req_cond = '0;
    flag_n = 0; flag_v = 0; flag_z = 0; flag_c = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_not_taken();
    test_same_page();
    test_cross_page();
    test_wrap();
    test_zero_offset();
    test_busy_ignore();
    test_cond_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule